// File: doc/BRIEF.md
# Memory Error Response Flag Unit

This unit takes already-classified uncorrectable memory error events and keeps the recovery status that a management controller polls. Each error event carries three things: whether containment worked, whether the device is running in partitioned mode, and the partition id. From these the unit decides which recovery actions are outstanding. A failed containment needs a whole-device reset. A contained error needs the faulty row repaired at the next reset. A contained error in partitioned mode also asks for the other partitions to be drained before that reset.

Two further inputs come from outside. An external spare-row table reports whether each repair entry was recorded, and an SRAM error source pulses once per uncorrectable SRAM hit. Every error and record outcome is written as a numeric code into a small event log that the controller pops. A lifetime SRAM counter raises a service-threshold output. A device-reset input marks the point where pending actions are applied. A separate factory-clear input wipes the state that is meant to survive device resets.

Top module: `merr_flag_unit`

## Requirements
- R1: An error event with containment failed sets `flag_reset_pend` on the next cycle. A contained event never sets it.
- R2: A contained error event sets `flag_remap_pend` on the next cycle. This happens in either partition mode.
- R3: `flag_drain` is set only by a contained event that arrives with `evt_partitioned` high. Uncontained events do not set it, and neither do contained events outside partitioned mode.
- R4: `dev_reset` clears `flag_reset_pend`, `flag_remap_pend` and `flag_drain`. If an error event arrives in the same cycle, the flags it sets end up set.
- R5: A record outcome with `rec_fail` high sets `flag_remap_fail`. That flag and the SRAM count both survive `dev_reset`. `factory_clr` clears them.
- R6: Each event is logged as one entry. The codes are 94 for a contained error, 95 for an uncontained error, 63 for a successful record and 64 for a failed record. An error entry carries the event's partition id, and a record entry carries id 0. When an error event and a record outcome arrive in the same cycle, the error entry is logged first.
- R7: The log holds 8 entries and reads out in arrival order. A new entry that finds the log full is dropped and sets the sticky `log_overflow`, which only `factory_clr` or `rst` clears. A pop in the same cycle does not free space for that cycle's entries.
- R8: `sram_count` counts `sram_uce` cycles and saturates at its maximum. `sram_service` is high exactly when the count is strictly greater than 4. When `factory_clr` and `sram_uce` arrive together, the count becomes 1.
- R9: `status_word` packs the flags as follows: bit0 reset pending, bit1 remap pending, bit2 remap failure, bit3 drain-and-reset, bit4 SRAM service threshold.
- R10: Synchronous `rst` clears every flag, the count, the log and the overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event strobe |
| evt_contained | input | 1 | 1 = containment succeeded |
| evt_partitioned | input | 1 | 1 = device in partitioned mode |
| evt_pid | input | 4 | Partition id of the event |
| rec_valid | input | 1 | Spare-row record outcome strobe |
| rec_fail | input | 1 | 1 = record failed |
| sram_uce | input | 1 | One uncorrectable SRAM error this cycle |
| dev_reset | input | 1 | Device reset applied; resolves pending actions |
| factory_clr | input | 1 | Clears persistent failure and lifetime state |
| log_pop | input | 1 | Remove the head entry of the log |
| log_valid | output | 1 | Log holds at least one entry |
| log_code | output | 8 | Code of the head entry |
| log_pid | output | 4 | Partition id of the head entry |
| log_overflow | output | 1 | Sticky: an entry was dropped |
| flag_reset_pend | output | 1 | Whole-device reset required |
| flag_remap_pend | output | 1 | Row repair waits for the next reset |
| flag_remap_fail | output | 1 | A repair record failed |
| flag_drain | output | 1 | Drain partitions, then reset |
| sram_service | output | 1 | SRAM count above threshold |
| sram_count | output | 8 | Lifetime SRAM uncorrectable count |
| status_word | output | 5 | Packed flags for register reads |

## Verification
The hardest state to reach is a full log that receives two entries in one cycle while the flags are also being cleared. In that state the per-cycle free-space arithmetic, the error-before-record ordering and the set-over-clear priority all interact. The stimulus first stops the draining monitor. It then fills the log with contained events that carry distinct partition ids, and adds a combined error-plus-record cycle so that both pending entries are dropped together. After that it resumes draining and compares the eight kept entries against the scoreboard in order. The SRAM saturation corner is reached by holding the error input high for more cycles than the counter can represent.

// File: rtl/merr_pkg.sv
package merr_pkg;

    localparam int PID_W  = 4;
    localparam int CODE_W = 8;
    localparam int STAT_W = 5;

    localparam logic [CODE_W-1:0] CODE_CONTAINED   = 8'd94;
    localparam logic [CODE_W-1:0] CODE_UNCONTAINED = 8'd95;
    localparam logic [CODE_W-1:0] CODE_REC_OK      = 8'd63;
    localparam logic [CODE_W-1:0] CODE_REC_FAIL    = 8'd64;

    localparam int ST_RESET_PEND = 0;
    localparam int ST_REMAP_PEND = 1;
    localparam int ST_REMAP_FAIL = 2;
    localparam int ST_DRAIN      = 3;
    localparam int ST_SRAM_SVC   = 4;

    typedef struct packed {
        logic             valid;
        logic             contained;
        logic             partitioned;
        logic [PID_W-1:0] pid;
    } err_evt_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PID_W-1:0]  pid;
    } log_entry_t;

    typedef struct packed {
        logic reset_pend;
        logic remap_pend;
        logic remap_fail;
        logic drain;
    } flags_t;

    function automatic log_entry_t err_entry(input err_evt_t e);
        log_entry_t r;
        r.code = e.contained ? CODE_CONTAINED : CODE_UNCONTAINED;
        r.pid  = e.pid;
        return r;
    endfunction

    function automatic log_entry_t rec_entry(input logic failed);
        log_entry_t r;
        r.code = failed ? CODE_REC_FAIL : CODE_REC_OK;
        r.pid  = '0;
        return r;
    endfunction

endpackage

// File: rtl/merr_flag_core.sv
module merr_flag_core
    import merr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_evt_t evt,
    input  logic     rec_valid,
    input  logic     rec_fail,
    input  logic     dev_reset,
    input  logic     factory_clr,
    output flags_t   flags
);

    flags_t f_q;
    logic   set_reset, set_remap, set_drain, set_fail;

    always_comb begin
        set_reset = evt.valid && !evt.contained;
        set_remap = evt.valid && evt.contained;
        set_drain = evt.valid && evt.contained && evt.partitioned;
        set_fail  = rec_valid && rec_fail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            if (set_reset)      f_q.reset_pend <= 1'b1;
            else if (dev_reset) f_q.reset_pend <= 1'b0;

            if (set_remap)      f_q.remap_pend <= 1'b1;
            else if (dev_reset) f_q.remap_pend <= 1'b0;

            if (set_drain)      f_q.drain <= 1'b1;
            else if (dev_reset) f_q.drain <= 1'b0;

            if (set_fail)         f_q.remap_fail <= 1'b1;
            else if (factory_clr) f_q.remap_fail <= 1'b0;
        end
    end

    assign flags = f_q;

    // R1
    uncont_sets_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !evt.contained) |=> flags.reset_pend);

    // R1
    reset_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.reset_pend) |-> $past(evt.valid && !evt.contained));

    // R3
    drain_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.drain) |-> $past(evt.valid && evt.contained && evt.partitioned));

    // R4
    dev_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_reset && !evt.valid) |=> !(flags.reset_pend || flags.remap_pend || flags.drain));

    // R5
    fail_persist_chk: assert property (@(posedge clk) disable iff (rst)
        !factory_clr |=> (flags.remap_fail || !$past(flags.remap_fail)));

endmodule

// File: rtl/merr_evt_log.sv
module merr_evt_log
    import merr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_a,
    input  log_entry_t data_a,
    input  logic       push_b,
    input  log_entry_t data_b,
    input  logic       pop,
    input  logic       clr_ovf,
    output logic       head_valid,
    output log_entry_t head,
    output logic       overflow
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

    log_entry_t    mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q, wp_b;
    logic [AW:0]   cnt_q, free_slots;
    logic          acc_a, acc_b, pop_ok, drop, ovf_q;

    always_comb begin
        free_slots = DEPTH_C - cnt_q;
        acc_a      = push_a && (free_slots != '0);
        acc_b      = push_b && (free_slots > (acc_a ? (AW+1)'(1) : (AW+1)'(0)));
        drop       = (push_a && !acc_a) || (push_b && !acc_b);
        pop_ok     = pop && (cnt_q != '0);
        wp_b       = acc_a ? wp_q + AW'(1) : wp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (acc_a) mem[wp_q] <= data_a;
            if (acc_b) mem[wp_b] <= data_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            wp_q  <= wp_q + AW'(acc_a) + AW'(acc_b);
            if (pop_ok) rp_q <= rp_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(acc_a) + (AW+1)'(acc_b) - (AW+1)'(pop_ok);
            if (drop)         ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;
        end
    end

    assign head_valid = (cnt_q != '0);
    assign head       = mem[rp_q];
    assign overflow   = ovf_q;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= DEPTH_C);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == DEPTH_C && (push_a || push_b)) |=> overflow);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clr_ovf) |=> overflow);

endmodule

// File: rtl/merr_sram_ctr.sv
module merr_sram_ctr #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             service
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LIM_C   = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                           cnt_q <= '0;
        else if (clr)                      cnt_q <= CNT_W'(hit);
        else if (hit && cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count   = cnt_q;
    assign service = cnt_q > LIM_C;

    // R8
    svc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(service) |-> ($past(cnt_q) == LIM_C));

    // R8
    monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt_q >= $past(cnt_q)));

    // R8
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/merr_flag_unit.sv
module merr_flag_unit
    import merr_pkg::*;
#(
    parameter int LOG_DEPTH  = 8,
    parameter int SRAM_CNT_W = 8,
    parameter int SRAM_LIMIT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  evt_valid,
    input  logic                  evt_contained,
    input  logic                  evt_partitioned,
    input  logic [PID_W-1:0]      evt_pid,
    input  logic                  rec_valid,
    input  logic                  rec_fail,
    input  logic                  sram_uce,
    input  logic                  dev_reset,
    input  logic                  factory_clr,
    input  logic                  log_pop,
    output logic                  log_valid,
    output logic [CODE_W-1:0]     log_code,
    output logic [PID_W-1:0]      log_pid,
    output logic                  log_overflow,
    output logic                  flag_reset_pend,
    output logic                  flag_remap_pend,
    output logic                  flag_remap_fail,
    output logic                  flag_drain,
    output logic                  sram_service,
    output logic [SRAM_CNT_W-1:0] sram_count,
    output logic [STAT_W-1:0]     status_word
);

    err_evt_t   evt;
    flags_t     flags;
    log_entry_t head;

    always_comb begin
        evt.valid       = evt_valid;
        evt.contained   = evt_contained;
        evt.partitioned = evt_partitioned;
        evt.pid         = evt_pid;
    end

    merr_flag_core u_core (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rec_valid   (rec_valid),
        .rec_fail    (rec_fail),
        .dev_reset   (dev_reset),
        .factory_clr (factory_clr),
        .flags       (flags)
    );

    merr_evt_log #(.DEPTH(LOG_DEPTH)) u_log (
        .clk        (clk),
        .rst        (rst),
        .push_a     (evt_valid),
        .data_a     (err_entry(evt)),
        .push_b     (rec_valid),
        .data_b     (rec_entry(rec_fail)),
        .pop        (log_pop),
        .clr_ovf    (factory_clr),
        .head_valid (log_valid),
        .head       (head),
        .overflow   (log_overflow)
    );

    merr_sram_ctr #(.CNT_W(SRAM_CNT_W), .LIMIT(SRAM_LIMIT)) u_sram (
        .clk     (clk),
        .rst     (rst),
        .hit     (sram_uce),
        .clr     (factory_clr),
        .count   (sram_count),
        .service (sram_service)
    );

    assign log_code        = head.code;
    assign log_pid         = head.pid;
    assign flag_reset_pend = flags.reset_pend;
    assign flag_remap_pend = flags.remap_pend;
    assign flag_remap_fail = flags.remap_fail;
    assign flag_drain      = flags.drain;

    always_comb begin
        status_word                = '0;
        status_word[ST_RESET_PEND] = flags.reset_pend;
        status_word[ST_REMAP_PEND] = flags.remap_pend;
        status_word[ST_REMAP_FAIL] = flags.remap_fail;
        status_word[ST_DRAIN]      = flags.drain;
        status_word[ST_SRAM_SVC]   = sram_service;
    end

endmodule

// File: tb/merr_flag_unit_tb.sv
`timescale 1ns/1ps
module merr_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_valid = 0, evt_contained = 0, evt_partitioned = 0;
    logic [3:0] evt_pid = '0;
    logic       rec_valid = 0, rec_fail = 0, sram_uce = 0;
    logic       dev_reset = 0, factory_clr = 0, log_pop = 0;
    logic       log_valid, log_overflow;
    logic [7:0] log_code;
    logic [3:0] log_pid;
    logic       flag_reset_pend, flag_remap_pend, flag_remap_fail, flag_drain, sram_service;
    logic [7:0] sram_count;
    logic [4:0] status_word;

    int n_chk = 0, n_bad = 0, m_occ = 0;
    bit mon_en = 1'b1, done = 1'b0;
    logic [11:0] sb_q [$];

    always #10 clk = ~clk;

    merr_flag_unit u_dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_contained(evt_contained),
        .evt_partitioned(evt_partitioned), .evt_pid(evt_pid), .rec_valid(rec_valid),
        .rec_fail(rec_fail), .sram_uce(sram_uce), .dev_reset(dev_reset),
        .factory_clr(factory_clr), .log_pop(log_pop), .log_valid(log_valid),
        .log_code(log_code), .log_pid(log_pid), .log_overflow(log_overflow),
        .flag_reset_pend(flag_reset_pend), .flag_remap_pend(flag_remap_pend),
        .flag_remap_fail(flag_remap_fail), .flag_drain(flag_drain),
        .sram_service(sram_service), .sram_count(sram_count), .status_word(status_word)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_entry(input logic [7:0] code, input logic [3:0] pid);
        if (m_occ < 8) begin
            sb_q.push_back({code, pid});
            m_occ++;
        end
    endtask

    // One cycle of stimulus; outputs are valid at the following negedge.
    task automatic drive(input bit ev, input bit cont, input bit part, input logic [3:0] pid,
                         input bit rv, input bit rf, input bit dr, input bit fc);
        @(negedge clk);
        evt_valid = ev; evt_contained = cont; evt_partitioned = part; evt_pid = pid;
        rec_valid = rv; rec_fail = rf; dev_reset = dr; factory_clr = fc;
        if (ev) expect_entry(cont ? 8'd94 : 8'd95, pid);
        if (rv) expect_entry(rf ? 8'd64 : 8'd63, 4'd0);
        @(negedge clk);
        evt_valid = 0; rec_valid = 0; dev_reset = 0; factory_clr = 0;
    endtask

    // Monitor: pops the log and compares each entry with the scoreboard (R6, R7).
    always @(negedge clk) begin
        if (mon_en && log_valid && !rst) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6: actual code %0d pid %0d expected no entry", log_code, log_pid);
            end else begin
                if ({log_code, log_pid} != sb_q[0]) begin
                    n_bad++;
                    $display("FAIL R6/R7: actual code %0d pid %0d expected code %0d pid %0d",
                             log_code, log_pid, sb_q[0][11:4], sb_q[0][3:0]);
                end
                void'(sb_q.pop_front());
            end
            m_occ--;
            log_pop = 1'b1;
        end else begin
            log_pop = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 status", status_word, 0);
        chk("R10 log_valid", log_valid, 0);
        chk("R10 count", sram_count, 0);

        // R2: contained, not partitioned -> remap pending only (R1, R3 negative)
        drive(1, 1, 0, 4'd2, 0, 0, 0, 0);
        chk("R2 contained status", status_word, 5'b00010);
        chk("R1 contained no reset_pend", flag_reset_pend, 0);
        chk("R3 unpartitioned no drain", flag_drain, 0);

        // R4 dev_reset clears
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R4 cleared", status_word, 0);

        // R3 partitioned contained
        drive(1, 1, 1, 4'd3, 0, 0, 0, 0);
        chk("R3 drain set", status_word, 5'b01010);

        // R1 uncontained, partitioned: reset pend, no new drain cause
        drive(1, 0, 1, 4'd5, 0, 0, 0, 0);
        chk("R1 reset pend", status_word, 5'b01011);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        drive(1, 0, 1, 4'd6, 0, 0, 0, 0);
        chk("R3 uncontained no drain", status_word, 5'b00001);

        // R4 event and dev_reset together: set wins
        drive(1, 1, 1, 4'd7, 0, 0, 1, 0);
        chk("R4 set beats clear", status_word, 5'b01010);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R4 cleared again", status_word, 0);

        // R5 record outcomes
        drive(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R5 ok record no flag", flag_remap_fail, 0);
        drive(0, 0, 0, 0, 1, 1, 0, 0);
        chk("R5 fail record", status_word, 5'b00100);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R5 survives dev_reset", status_word, 5'b00100);

        // R6 same-cycle ordering: error entry before record entry
        drive(1, 0, 0, 4'd9, 1, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 1, 0);

        // R8 SRAM threshold
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); sram_uce = 1;
            @(negedge clk); sram_uce = 0;
        end
        chk("R8 count 4", sram_count, 4);
        chk("R8 not above 4", sram_service, 0);
        @(negedge clk); sram_uce = 1;
        @(negedge clk); sram_uce = 0;
        chk("R8 above 4", sram_service, 1);
        chk("R9 status bits", status_word, 5'b10100);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R5 count survives dev_reset", sram_count, 5);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5 factory clear", status_word, 0);
        chk("R5 count cleared", sram_count, 0);

        // R8 clear together with hit loads 1
        @(negedge clk); sram_uce = 1; factory_clr = 1;
        @(negedge clk); sram_uce = 0; factory_clr = 0;
        chk("R8 clear with hit", sram_count, 1);

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", sb_q.size(), 0);

        // R7 fill and overflow with monitor stopped
        mon_en = 0;
        @(negedge clk);
        for (int i = 0; i < 7; i++) drive(1, 1, 0, 4'(i), 0, 0, 0, 0);
        chk("R7 no overflow at 7", log_overflow, 0);
        drive(1, 1, 1, 4'd7, 1, 0, 0, 0);
        chk("R7 overflow on 9th", log_overflow, 1);
        drive(1, 0, 0, 4'd12, 1, 1, 0, 0);
        chk("R7 still overflow", log_overflow, 1);
        mon_en = 1;
        repeat (12) @(negedge clk);
        chk("R7 all kept entries read", sb_q.size(), 0);
        chk("R7 empty after drain", log_valid, 0);
        chk("R7 overflow sticky", log_overflow, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R7 overflow cleared", log_overflow, 0);

        // R8 saturation
        @(negedge clk); sram_uce = 1;
        repeat (260) @(negedge clk);
        sram_uce = 0;
        chk("R8 saturated", sram_count, 255);

        // R10 reset clears everything
        drive(1, 0, 1, 4'd1, 1, 1, 0, 0);
        mon_en = 0;
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        sb_q.delete(); m_occ = 0;
        @(negedge clk);
        chk("R10 status after rst", status_word, 0);
        chk("R10 count after rst", sram_count, 0);
        chk("R10 log after rst", log_valid, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule